// File: doc/BRIEF.md
# Shared GPIO Port with Analog Masking

This block is a general-purpose I/O port of parameterised width (16 pins by default) with a small register interface. It holds three registers: an output data latch, a direction register and an analog-select register. Each pin has an output multiplexer. The multiplexer drives the pad from the latch and direction register, or from an attached peripheral when that pin's peripheral-enable bit is set. The pad is modelled as an output-data vector, an output-enable vector and an input-level vector, so no tri-state net is needed.

Reads return one of three sources: the latch, the direction register, or the registered sample of the pin levels. A pin marked as analog always reads as 0 in the sampled view. The pin levels pass through a sample register. After software writes the latch or changes direction, the new pin state reaches the port read one cycle later, so software must leave one idle cycle before it reads the port.

Top module: `gpio_shared_port`

## Requirements
- R1: With the peripheral disabled on a pin, a direction bit of 1 makes the pin an input (pad_oe bit 0), and a direction bit of 0 makes it an output (pad_oe bit 1) that drives the latch bit on pad_out.
- R2: After reset the direction register reads 0xFFFF (all pins are inputs), and the latch and the analog-select register read 0.
- R3: A write to address 0 (port) and a write to address 1 (latch) both load the latch on that clock edge. A read of address 1 returns the latch.
- R4: A write to address 2 loads the direction register, and a read of address 2 returns it.
- R5: A read of address 0 returns the pin levels captured at the previous clock edge. After a latch write, a port read in the next cycle still shows the old pin level, and the read one cycle after that shows the new level.
- R6: Address 3 holds the analog-select register. Every pin whose analog-select bit is 1 reads as 0 through address 0, whatever its level.
- R7: When a pin's periph_en bit is 1, its pad_out bit follows periph_out and its pad_oe bit follows periph_oe, regardless of the latch and direction register.
- R8: periph_in always equals pin_in, whichever source drives the output.
- R9: Writing 0xFF00 to the direction register makes pins 15..8 inputs and pins 7..0 outputs.
- R10: Writes to addresses 4..7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, qualified by addr |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data |
| pin_in | input | 16 | Level seen at each pad |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable, 1 = drive |
| periph_en | input | 16 | Per-pin peripheral ownership |
| periph_out | input | 16 | Peripheral output data |
| periph_oe | input | 16 | Peripheral output enable |
| periph_in | output | 16 | Pin level routed to the peripheral |

## Verification
A wrong latch or direction bit appears on pad_out or pad_oe in the cycle right after the write edge, and the bench reads back both registers in that cycle. A fault in the sample register or in the analog mask appears only through address 0. The bench therefore drives pins through a loopback model and reads both in the cycle right after a write and in the cycle after that, which exposes a missing or extra stage of read latency. A faulty override multiplexer appears on the pad vectors as soon as periph_en changes, so mixed patterns of owned and unowned pins are checked bit for bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PORT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ANA  = 3'd3;

  // Sampled pin view with analog-selected pins forced low
  function automatic logic [15:0] masked_view(input logic [15:0] samp,
                                              input logic [15:0] ana);
    return samp & ~ana;
  endfunction

  // Pad enable for one pin: direction 0 means drive, unless a peripheral owns it
  function automatic logic pin_oe(input logic own, input logic dir_bit,
                                  input logic per_oe);
    return own ? per_oe : ~dir_bit;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  ana_q
);
  logic wr_lat, wr_dir, wr_ana;

  assign wr_lat = wr_en && (addr == A_PORT || addr == A_LAT);
  assign wr_dir = wr_en && (addr == A_DIR);
  assign wr_ana = wr_en && (addr == A_ANA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
      ana_q   <= '0;
    end else begin
      if (wr_lat) latch_q <= wr_data;
      if (wr_dir) dir_q   <= wr_data;
      if (wr_ana) ana_q   <= wr_data;
    end
  end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] samp_q
);
  // Free-running capture; no reset so the sample always trails the pins by one edge
  always_ff @(posedge clk) begin
    samp_q <= pin_in;
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      pad_out[i] = periph_en[i] ? periph_out[i] : latch_q[i];
      pad_oe[i]  = pin_oe(periph_en[i], dir_q[i], periph_oe[i]);
    end
  end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  periph_en,
  input  logic [WIDTH-1:0]  periph_out,
  input  logic [WIDTH-1:0]  periph_oe,
  output logic [WIDTH-1:0]  periph_in
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] ana_q;
  logic [WIDTH-1:0] samp_q;
  logic [WIDTH-1:0] port_view;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .latch_q(latch_q), .dir_q(dir_q), .ana_q(ana_q)
  );

  gpio_in_sample #(.WIDTH(WIDTH)) u_samp (
    .clk(clk), .pin_in(pin_in), .samp_q(samp_q)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .periph_en(periph_en),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign periph_in = pin_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_view
    assign port_view[i] = samp_q[i] & ~ana_q[i];
  end

  always_comb begin
    unique case (addr)
      A_PORT:  rd_data = port_view;
      A_LAT:   rd_data = latch_q;
      A_DIR:   rd_data = dir_q;
      A_ANA:   rd_data = ana_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [WIDTH-1:0]  rd_data,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  periph_en,
  input logic [WIDTH-1:0]  periph_out,
  input logic [WIDTH-1:0]  periph_oe,
  input logic [WIDTH-1:0]  latch_q,
  input logic [WIDTH-1:0]  ana_q
);
  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR && periph_en == '0) |=>
      (periph_en != '0 || pad_oe == ~$past(wr_data))); // R1

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_PORT || addr == A_LAT)) |=> latch_q == $past(wr_data)); // R3

  AST_SAMPLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_PORT) |-> rd_data == ($past(pin_in) & ~ana_q)); // R5

  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_PORT) |-> (rd_data & ana_q) == '0); // R6

  AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ periph_out) & periph_en) == '0) &&
    (((pad_oe ^ periph_oe) & periph_en) == '0)); // R7

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > A_ANA) |-> rd_data == '0); // R10
endmodule

bind gpio_shared_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe),
  .latch_q(latch_q), .ana_q(ana_q)
);

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pin_in;
  logic [W-1:0] pad_out, pad_oe;
  logic [W-1:0] periph_en = '0, periph_out = '0, periph_oe = '0;
  logic [W-1:0] periph_in;
  logic [W-1:0] ext_lvl = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // Pad loopback: a driven pin reads its own output, an undriven pin reads the outside level
  assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  gpio_shared_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(3'd2, v); check("R2 dir reset", v, 16'hFFFF);
    rd(3'd1, v); check("R2 latch reset", v, 16'h0000);
    rd(3'd3, v); check("R2 analog reset", v, 16'h0000);
    check("R1 all inputs after reset", pad_oe, 16'h0000);
  endtask

  task automatic t_dir_split();
    logic [W-1:0] v;
    wr(3'd1, 16'hA5C3);
    wr(3'd2, 16'hFF00);
    check("R9 low byte driven", pad_oe, 16'h00FF);
    check("R1 output bits from latch", pad_out & pad_oe, 16'h00C3);
    rd(3'd2, v); check("R4 dir readback", v, 16'hFF00);
  endtask

  task automatic t_latch_paths();
    logic [W-1:0] v;
    rd(3'd1, v); check("R3 latch readback", v, 16'hA5C3);
    wr(3'd0, 16'h1234);
    rd(3'd1, v); check("R3 port write loads latch", v, 16'h1234);
    wr(3'd2, 16'h0F0F);
    check("R1 mixed direction", pad_oe, 16'hF0F0);
    rd(3'd2, v); check("R4 second dir value", v, 16'h0F0F);
  endtask

  task automatic t_read_lag();
    logic [W-1:0] v;
    ext_lvl = '0;
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0000);
    @(negedge clk);
    wr(3'd1, 16'hBEEF);
    rd(3'd0, v); check("R5 first read still old", v, 16'h0000);
    @(negedge clk);
    rd(3'd0, v); check("R5 second read new", v, 16'hBEEF);
  endtask

  task automatic t_inputs_analog();
    logic [W-1:0] v;
    wr(3'd2, 16'hFFFF);
    ext_lvl = 16'h5A5A;
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); check("R5 external levels", v, 16'h5A5A);
    wr(3'd3, 16'h00F0);
    rd(3'd0, v); check("R6 analog pins zero", v, 16'h5A0A);
    rd(3'd3, v); check("R6 analog readback", v, 16'h00F0);
    wr(3'd3, 16'hFFFF);
    rd(3'd0, v); check("R6 all analog", v, 16'h0000);
    wr(3'd3, 16'h0000);
  endtask

  task automatic t_periph();
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'hFFFF);
    ext_lvl = 16'h3C3C;
    @(negedge clk);
    periph_en = 16'h000F; periph_out = 16'h0005; periph_oe = 16'h0003;
    #1;
    check("R7 periph data", pad_out, 16'hFFF5);
    check("R7 periph enable", pad_oe, 16'hFFF3);
    check("R8 periph input", periph_in, (pad_oe & pad_out) | (~pad_oe & 16'h3C3C));
    periph_en = 16'hF000; periph_out = 16'h0000; periph_oe = 16'h0000;
    #1;
    check("R7 periph releases low nibble", pad_oe, 16'h0FFF);
    check("R8 input on undriven pins", periph_in & 16'hF000, 16'h3000);
    @(negedge clk);
    periph_en = '0;
  endtask

  task automatic t_bad_addr();
    logic [W-1:0] v;
    wr(3'd2, 16'h1111);
    wr(3'd1, 16'h2222);
    wr(3'd3, 16'h4444);
    wr(3'd5, 16'h0000);
    wr(3'd7, 16'hFFFF);
    rd(3'd2, v); check("R10 dir untouched", v, 16'h1111);
    rd(3'd1, v); check("R10 latch untouched", v, 16'h2222);
    rd(3'd3, v); check("R10 analog untouched", v, 16'h4444);
    rd(3'd6, v); check("R10 unmapped reads zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_split();
    t_latch_paths();
    t_read_lag();
    t_inputs_analog();
    t_periph();
    t_bad_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule